// File: doc/BRIEF.md
# Debug Breakpoint Register Bank

This block holds four debug breakpoint registers that a processor reaches through one access-space code. They are an address value, an address mask, a control word and a status word. Software writes and reads them with a single-cycle read or write strobe that carries an address and 64-bit data. Breakpoint match logic outside the block reports events on a set input, and those events build up in the status register.

Each register keeps only its implemented width on write. Bits above that width always read as zero. A read of the status word returns the value the word held and clears it in the same step, so software sees each event once. A read returns its data one cycle after the strobe. The reset input is asynchronous and active low, and its release is synchronised inside the block.

Top module: `bp_regbank`

## Requirements
- R1: A strobe takes effect only when `req_space` equals 0x38. A strobe with any other space code changes no register and gives no response.
- R2: Address bits 9:8 pick the register: 0 is the address value, 1 is the address mask, 2 is the control word and 3 is the status word. All other address bits are ignored.
- R3: A write to the address value or the address mask keeps bits 35:0 of the write data. Bits 63:36 read as zero.
- R4: A write to the control word keeps bits 6:0 of the write data. Bits 63:7 read as zero.
- R5: A write to the status word keeps bits 3:0 of the write data. Bits 63:4 read as zero.
- R6: A read that hits the bank raises `rsp_valid` for exactly the next cycle, with the register contents on `rsp_rdata`. In every other cycle `rsp_valid` is low and `rsp_rdata` is zero.
- R7: A read of the status word returns its current value and leaves it at zero afterwards.
- R8: A read of the value, mask or control register changes no register.
- R9: Each set bit of `evt_set` is ORed into status bits 3:0 in that cycle. This happens whatever access occurs in the same cycle, including a clearing read of the status word.
- R10: After reset, all four registers read as zero.
- R11: When a read and a write hit the bank in the same cycle, the read returns the value from before the write and the write is applied. On the status word the write takes the place of the clear.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_rd | input | 1 | Read strobe |
| req_wr | input | 1 | Write strobe |
| req_space | input | 8 | Access-space code of the request |
| req_addr | input | 12 | Request address; bits 9:8 pick the register |
| req_wdata | input | 64 | Write data |
| evt_set | input | 4 | Event bits to OR into the status word |
| rsp_valid | output | 1 | Read data valid, one cycle after a hitting read |
| rsp_rdata | output | 64 | Read data, zero when not valid |

## Verification
The checker tests several rules on every cycle. It checks the one-cycle read latency and a quiet response bus when there is no read. It checks that the control read data has zero upper bits, that status event bits always land, that a clearing read without a concurrent set or write leaves the status at zero, and that the bank holds still when nothing writes it or clears it. Other behaviours are shown only by the bench's scenarios against a reference model. These are the exact masking of each register, that foreign space codes and unused address bits have no effect, and the ordering of a read and a write to the same register in one cycle.

// File: rtl/bp_regbank_pkg.sv
package bp_regbank_pkg;
  localparam int unsigned BP_DATA_W   = 64;
  localparam int unsigned BP_ADDR_W   = 12;
  localparam int unsigned BP_SPACE_W  = 8;
  localparam int unsigned BP_SEL_LSB  = 8;
  localparam int unsigned BP_VAL_W    = 36;
  localparam int unsigned BP_CTL_W    = 7;
  localparam int unsigned BP_STS_W    = 4;
  localparam int unsigned BP_NUM_REGS = 4;

  typedef enum logic [1:0] {
    BP_IDX_VALUE  = 2'd0,
    BP_IDX_MASK   = 2'd1,
    BP_IDX_CTRL   = 2'd2,
    BP_IDX_STATUS = 2'd3
  } bp_idx_e;
endpackage

// File: rtl/bp_field_reg.sv
module bp_field_reg #(
  parameter int unsigned DATA_W = 64,
  parameter int unsigned KEEP_W = 36
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] q
);
  localparam int unsigned PAD_W = DATA_W - KEEP_W;

  logic [KEEP_W-1:0] q_r;
  logic [KEEP_W-1:0] q_nx;
  logic              unused_hi;

  assign unused_hi = ^wdata[DATA_W-1:KEEP_W];

  always_comb begin
    q_nx = q_r;
    if (we) q_nx = wdata[KEEP_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_r <= '0;
    else if (we) q_r <= q_nx;
  end

  assign q = {{PAD_W{1'b0}}, q_r};
endmodule

// File: rtl/bp_status_reg.sv
module bp_status_reg #(
  parameter int unsigned DATA_W = 64,
  parameter int unsigned KEEP_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [DATA_W-1:0] wdata,
  input  logic              clr,
  input  logic [KEEP_W-1:0] set,
  output logic [DATA_W-1:0] q
);
  localparam int unsigned PAD_W = DATA_W - KEEP_W;

  logic [KEEP_W-1:0] q_r;
  logic [KEEP_W-1:0] q_nx;
  logic              upd_en;
  logic              unused_hi;

  assign unused_hi = ^wdata[DATA_W-1:KEEP_W];
  assign upd_en    = we | clr | (|set);

  always_comb begin
    q_nx = q_r;
    if (clr) q_nx = '0;
    if (we)  q_nx = wdata[KEEP_W-1:0];
    q_nx = q_nx | set;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_r <= '0;
    else if (upd_en) q_r <= q_nx;
  end

  assign q = {{PAD_W{1'b0}}, q_r};
endmodule

// File: rtl/bp_decode.sv
module bp_decode #(
  parameter int unsigned ADDR_W     = 12,
  parameter int unsigned SPACE_W    = 8,
  parameter int unsigned SEL_LSB    = 8,
  parameter int unsigned NUM_REGS   = 4,
  parameter logic [SPACE_W-1:0] SPACE_CODE = 8'h38
) (
  input  logic               req_rd,
  input  logic               req_wr,
  input  logic [SPACE_W-1:0] req_space,
  input  logic [ADDR_W-1:0]  req_addr,
  output logic               rd_hit,
  output logic [NUM_REGS-1:0] rd_sel,
  output logic [NUM_REGS-1:0] wr_sel
);
  localparam int unsigned IDX_W = $clog2(NUM_REGS);

  logic             space_ok;
  logic [IDX_W-1:0] idx;
  logic             unused_addr;

  assign space_ok    = (req_space == SPACE_CODE);
  assign idx         = req_addr[SEL_LSB +: IDX_W];
  assign unused_addr = ^{req_addr[ADDR_W-1:SEL_LSB+IDX_W], req_addr[SEL_LSB-1:0]};
  assign rd_hit      = req_rd & space_ok;

  always_comb begin
    rd_sel = '0;
    wr_sel = '0;
    for (int i = 0; i < int'(NUM_REGS); i++) begin
      rd_sel[i] = rd_hit & (idx == IDX_W'(i));
      wr_sel[i] = req_wr & space_ok & (idx == IDX_W'(i));
    end
  end
endmodule

// File: rtl/bp_read_port.sv
module bp_read_port #(
  parameter int unsigned DATA_W   = 64,
  parameter int unsigned NUM_REGS = 4
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             rd_hit,
  input  logic [NUM_REGS-1:0]              rd_sel,
  input  logic [NUM_REGS-1:0][DATA_W-1:0]  regs,
  output logic                             rsp_valid,
  output logic [DATA_W-1:0]                rsp_rdata
);
  logic [DATA_W-1:0] mux_d;
  logic [DATA_W-1:0] rdata_nx;
  logic              rdata_en;

  always_comb begin
    mux_d = '0;
    for (int i = 0; i < int'(NUM_REGS); i++) begin
      if (rd_sel[i]) mux_d = mux_d | regs[i];
    end
  end

  assign rdata_nx = rd_hit ? mux_d : '0;
  assign rdata_en = rd_hit | rsp_valid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= rd_hit;
      if (rdata_en) rsp_rdata <= rdata_nx;
    end
  end
endmodule

// File: rtl/bp_regbank.sv
module bp_regbank
  import bp_regbank_pkg::*;
#(
  parameter int unsigned DATA_W  = BP_DATA_W,
  parameter int unsigned ADDR_W  = BP_ADDR_W,
  parameter int unsigned SPACE_W = BP_SPACE_W,
  parameter int unsigned SEL_LSB = BP_SEL_LSB,
  parameter int unsigned VAL_W   = BP_VAL_W,
  parameter int unsigned CTL_W   = BP_CTL_W,
  parameter int unsigned STS_W   = BP_STS_W,
  parameter logic [SPACE_W-1:0] SPACE_CODE = 8'h38
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_rd,
  input  logic               req_wr,
  input  logic [SPACE_W-1:0] req_space,
  input  logic [ADDR_W-1:0]  req_addr,
  input  logic [DATA_W-1:0]  req_wdata,
  input  logic [STS_W-1:0]   evt_set,
  output logic               rsp_valid,
  output logic [DATA_W-1:0]  rsp_rdata
);
  localparam int unsigned NUM_REGS = BP_NUM_REGS;
  localparam int unsigned STS_IDX  = int'(BP_IDX_STATUS);

  logic [1:0]                         rst_pipe;
  logic                               rst_sync_n;
  logic                               rd_hit;
  logic [NUM_REGS-1:0]                rd_sel;
  logic [NUM_REGS-1:0]                wr_sel;
  logic [NUM_REGS-1:0][DATA_W-1:0]    reg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  bp_decode #(
    .ADDR_W(ADDR_W), .SPACE_W(SPACE_W), .SEL_LSB(SEL_LSB),
    .NUM_REGS(NUM_REGS), .SPACE_CODE(SPACE_CODE)
  ) u_dec (
    .req_rd(req_rd), .req_wr(req_wr), .req_space(req_space),
    .req_addr(req_addr), .rd_hit(rd_hit), .rd_sel(rd_sel), .wr_sel(wr_sel)
  );

  for (genvar g = 0; g < int'(STS_IDX); g++) begin : g_plain
    localparam int unsigned KW = (g == int'(BP_IDX_CTRL)) ? CTL_W : VAL_W;
    bp_field_reg #(.DATA_W(DATA_W), .KEEP_W(KW)) u_reg (
      .clk(clk), .rst_n(rst_sync_n), .we(wr_sel[g]),
      .wdata(req_wdata), .q(reg_q[g])
    );
  end

  bp_status_reg #(.DATA_W(DATA_W), .KEEP_W(STS_W)) u_sts (
    .clk(clk), .rst_n(rst_sync_n), .we(wr_sel[STS_IDX]), .wdata(req_wdata),
    .clr(rd_sel[STS_IDX]), .set(evt_set), .q(reg_q[STS_IDX])
  );

  bp_read_port #(.DATA_W(DATA_W), .NUM_REGS(NUM_REGS)) u_rd (
    .clk(clk), .rst_n(rst_sync_n), .rd_hit(rd_hit), .rd_sel(rd_sel),
    .regs(reg_q), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata)
  );
endmodule

// File: rtl/bp_regbank_chk.sv
module bp_regbank_chk #(
  parameter int unsigned DATA_W  = 64,
  parameter int unsigned ADDR_W  = 12,
  parameter int unsigned SPACE_W = 8,
  parameter int unsigned SEL_LSB = 8,
  parameter int unsigned CTL_W   = 7,
  parameter int unsigned STS_W   = 4,
  parameter logic [SPACE_W-1:0] SPACE_CODE = 8'h38
) (
  input logic                       clk,
  input logic                       rst_sync_n,
  input logic                       req_rd,
  input logic                       req_wr,
  input logic [SPACE_W-1:0]         req_space,
  input logic [ADDR_W-1:0]          req_addr,
  input logic [STS_W-1:0]           evt_set,
  input logic                       rsp_valid,
  input logic [DATA_W-1:0]          rsp_rdata,
  input logic [3:0][DATA_W-1:0]     reg_q
);
  logic       hit;
  logic [1:0] idx;
  assign hit = (req_space == SPACE_CODE);
  assign idx = req_addr[SEL_LSB +: 2];

  AST_RD_LATENCY: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (req_rd && hit) |=> rsp_valid); // R6
  AST_RSP_QUIET: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !(req_rd && hit) |=> (!rsp_valid && rsp_rdata == '0)); // R6
  AST_CTL_WIDTH: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (req_rd && hit && idx == 2'd2) |=> (rsp_rdata[DATA_W-1:CTL_W] == '0)); // R4
  AST_STS_CLEAR: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (req_rd && hit && idx == 2'd3 && !req_wr && evt_set == '0) |=> (reg_q[3] == '0)); // R7
  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (evt_set != '0) |=> ((reg_q[3][STS_W-1:0] & $past(evt_set)) == $past(evt_set))); // R9
  AST_READ_QUIET: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!(req_wr && hit) && evt_set == '0 && !(req_rd && hit && idx == 2'd3)) |=> $stable(reg_q)); // R8
endmodule

bind bp_regbank bp_regbank_chk #(
  .DATA_W(DATA_W), .ADDR_W(ADDR_W), .SPACE_W(SPACE_W), .SEL_LSB(SEL_LSB),
  .CTL_W(CTL_W), .STS_W(STS_W), .SPACE_CODE(SPACE_CODE)
) u_chk (
  .clk(clk), .rst_sync_n(rst_sync_n), .req_rd(req_rd), .req_wr(req_wr),
  .req_space(req_space), .req_addr(req_addr), .evt_set(evt_set),
  .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .reg_q(reg_q)
);

// File: tb/sim_bp_regbank.sv
module sim_bp_regbank;
  logic        clk;
  logic        rst_n;
  logic        req_rd;
  logic        req_wr;
  logic [7:0]  req_space;
  logic [11:0] req_addr;
  logic [63:0] req_wdata;
  logic [3:0]  evt_set;
  logic        rsp_valid;
  logic [63:0] rsp_rdata;

  int total = 0;
  int bad   = 0;
  logic [63:0] mdl [4];

  bp_regbank u0 (
    .clk(clk), .rst_n(rst_n), .req_rd(req_rd), .req_wr(req_wr),
    .req_space(req_space), .req_addr(req_addr), .req_wdata(req_wdata),
    .evt_set(evt_set), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic logic [63:0] keep_mask(int idx);
    case (idx)
      0, 1:    return 64'h0000_000F_FFFF_FFFF;
      2:       return 64'h7F;
      default: return 64'hF;
    endcase
  endfunction

  function automatic string req_tag(int idx);
    case (idx)
      0, 1:    return "R3";
      2:       return "R4";
      default: return "R7";
    endcase
  endfunction

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // One bus cycle: drive at a falling edge, check the response at the next one.
  task automatic cyc(bit rd, bit wr, logic [7:0] sp, logic [11:0] ad,
                     logic [63:0] wd, logic [3:0] ev, string tag);
    bit          hit = (sp == 8'h38);
    int          ix  = int'(ad[9:8]);
    logic [63:0] exp_d = (rd && hit) ? mdl[ix] : 64'h0;
    req_rd = rd; req_wr = wr; req_space = sp; req_addr = ad;
    req_wdata = wd; evt_set = ev;
    @(negedge clk);
    check({tag, " valid"}, {63'h0, rsp_valid}, {63'h0, rd && hit});
    check({tag, " data"}, rsp_rdata, exp_d);
    if (rd && hit && ix == 3) mdl[3] = 64'h0;
    if (wr && hit) mdl[ix] = wd & keep_mask(ix);
    mdl[3] = mdl[3] | {60'h0, ev};
    req_rd = 1'b0; req_wr = 1'b0; evt_set = 4'h0;
  endtask

  task automatic rd_only(int ix, string tag);
    cyc(1'b1, 1'b0, 8'h38, {2'b00, 2'(ix), 8'h00}, 64'h0, 4'h0, tag);
  endtask

  task automatic wr_only(int ix, logic [63:0] d, string tag);
    cyc(1'b0, 1'b1, 8'h38, {2'b00, 2'(ix), 8'h00}, d, 4'h0, tag);
  endtask

  initial begin
    #2_000_000;
    bad++; total++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h1234_5678));
    for (int i = 0; i < 4; i++) mdl[i] = 64'h0;
    rst_n = 1'b0; req_rd = 0; req_wr = 0; req_space = 0; req_addr = 0;
    req_wdata = 0; evt_set = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R10: reset values
    for (int i = 0; i < 4; i++) rd_only(i, "R10");
    // R3 / R4 / R5: widths
    for (int i = 0; i < 4; i++) wr_only(i, 64'hFFFF_FFFF_FFFF_FFFF, "R5");
    for (int i = 0; i < 4; i++) rd_only(i, req_tag(i));
    // R7: status read clears
    rd_only(3, "R7");
    // R1: foreign space code ignored
    cyc(1'b0, 1'b1, 8'h39, 12'h000, 64'h5A5A, 4'h0, "R1");
    cyc(1'b1, 1'b0, 8'h18, 12'h000, 64'h0, 4'h0, "R1");
    rd_only(0, "R1");
    // R2: other address bits ignored
    cyc(1'b0, 1'b1, 8'h38, 12'hEF7, 64'h123, 4'h0, "R2");
    cyc(1'b1, 1'b0, 8'h38, 12'h2AA, 64'h0, 4'h0, "R2");
    // R8: reads have no side effects
    rd_only(2, "R8"); rd_only(2, "R8"); rd_only(1, "R8");
    // R9: set wins over a clearing read
    wr_only(3, 64'h3, "R5");
    cyc(1'b1, 1'b0, 8'h38, 12'h300, 64'h0, 4'h4, "R9");
    rd_only(3, "R9");
    // R11: same-cycle read and write
    cyc(1'b1, 1'b1, 8'h38, 12'h100, 64'hABC, 4'h0, "R11");
    rd_only(1, "R11");
    wr_only(3, 64'h9, "R11");
    cyc(1'b1, 1'b1, 8'h38, 12'h300, 64'h6, 4'h0, "R11");
    rd_only(3, "R11");
    // R6 and mixed traffic
    for (int n = 0; n < 600; n++) begin
      logic [7:0] sp = ($urandom_range(0, 7) == 0) ? 8'($urandom) : 8'h38;
      logic [11:0] ad = 12'($urandom);
      logic [3:0]  ev = ($urandom_range(0, 3) == 0) ? 4'($urandom) : 4'h0;
      cyc(1'($urandom), 1'($urandom), sp, ad, {$urandom, $urandom}, ev,
          {"R6 ", req_tag(int'(ad[9:8]))});
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule